// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block decodes the upper bits of a 24-bit bus address, the 3-bit function code and the transfer direction against four programmable channels. Each channel drives one active-low select line. A host processor programs every channel through two 16-bit registers: a base word and an option word. The decoder finds the matching channel while the address strobe is low and asserts that channel's select line.

For the selected channel, the block also times the data acknowledge. It waits a programmable number of clocks and then asserts the acknowledge itself, or it leaves the acknowledge to an external device. A write that lands in a region programmed as read-only is refused: the block raises a bus error and latches a sticky write-protect flag, which software clears.

Addresses are decoded in 8 KB granules. The option word holds a per-bit address mask, so a channel can cover any power-of-two block from 8 KB to 16 MB. After reset, channel 0 covers the whole space, so a boot ROM can be reached on the very first bus cycle.

Top module: `csel_unit`

## Requirements
- R1: Register index 2*c reads and writes the base word of channel c, and index 2*c+1 its option word (c = 0..3). Index 8 is the status word, whose bit 0 is the write-protect flag. A write lands at the next clock edge. Read data follows the index combinationally.
- R2: After reset, channel 0's base word is 0x0001 and every other base word is 0x0000. Every option word is 0xC000 (6 wait states, no address, code or direction compare). The write-protect flag is 0, so channel 0 selects every bus cycle.
- R3: Base bits 12..2 hold the channel's address bits A23..A13. Option bits 12..2 form a mask in the same bit order: a mask bit of 1 compares that address bit and a 0 ignores it.
- R4: A channel whose base bit 0 (enable) is 0 never asserts its select line and never causes a bus error.
- R5: When option bit 0 is 1, base bits 15..13 must equal bus_fc. When it is 0, the function code is ignored.
- R6: When option bit 1 is 1, the channel's direction is checked against base bit 1: a 0 means reads only and a 1 means writes only. When option bit 1 is 0, both directions match.
- R7: Among the channels that fully match, only the lowest-numbered one asserts its select line. While bus_as_n is high, every select line is high.
- R8: A write cycle is a write-protect violation when no channel fully matches and some enabled channel matches on address and function code with direction compare on and base bit 1 equal to 0. During the strobe this drives berr_n low with no select line active. It also sets the write-protect flag at the next clock edge.
- R9: The write-protect flag stays set until a write of 1 to status bit 0. A write of 0 leaves it set, and a new violation in the same cycle wins over the clear.
- R10: Option bits 15..13 give W. For W = 0..6, dtack_n goes low once the strobe has been low across W rising clock edges, while a line is selected. W = 7 never drives dtack_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index (base/option per channel, status at 8) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_addr | input | 11 | Bus address bits A23..A13 |
| bus_fc | input | 3 | Bus function code |
| bus_read | input | 1 | Transfer direction, 1 = read |
| cs_n | output | 4 | Select lines, active low, one per channel |
| dtack_n | output | 1 | Internally timed data acknowledge, active low |
| berr_n | output | 1 | Bus error on write-protect violation, active low |
| wpv | output | 1 | Sticky write-protect flag |

## Verification
A stale or corrupted base or option word shows up at once: the select lines are wrong in the same cycle the strobe falls, and the bench sweeps every address granule, function code and direction against a four-channel layout with overlapping regions. A wrong wait counter shows up only as dtack_n arriving one or more edges early or late, so every wait code is timed edge by edge. A write-protect flag that clears itself or never sets shows on the wpv port one edge after the offending strobe, and it is read back through the status word.

// File: rtl/csel_pkg.sv
// Shared field layout for the chip-select decoder.
// Assumes 16-bit control words and 8 KB decode granules on a 24-bit bus.
package csel_pkg;
    localparam int CS_REG_W  = 16;
    localparam int CS_FC_W   = 3;
    localparam int CS_HI_W   = 11;   // address bits A23..A13
    localparam int CS_WST_W  = 3;
    localparam logic [CS_WST_W-1:0] WST_EXT = '1;  // external acknowledge

    typedef struct packed {
        logic [CS_FC_W-1:0] fc;
        logic [CS_HI_W-1:0] base;
        logic               wr_only;   // 0 = read region, 1 = write region
        logic               en;
    } base_word_t;

    typedef struct packed {
        logic [CS_WST_W-1:0] wst;
        logic [CS_HI_W-1:0]  mask;     // 1 = compare this address bit
        logic                dir_chk;
        logic                fc_chk;
    } opt_word_t;
endpackage

// File: rtl/csel_regs.sv
// Register file: base/option word per channel plus sticky write-protect flag.
// Assumes a single-cycle host write port and combinational read-back.
module csel_regs
    import csel_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int RA_W  = $clog2(2*NUM_CH+1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [RA_W-1:0]           addr,
    input  logic [CS_REG_W-1:0]       wdata,
    input  logic                      viol_evt,
    output base_word_t [NUM_CH-1:0]   base_q,
    output opt_word_t  [NUM_CH-1:0]   opt_q,
    output logic                      wpv_q,
    output logic [CS_REG_W-1:0]       rdata
);
    localparam logic [RA_W-1:0] STAT_IDX = RA_W'(2*NUM_CH);
    localparam opt_word_t OPT_RST = '{wst: 3'd6, mask: '0, dir_chk: 1'b0, fc_chk: 1'b0};

    // Hold and update the per-channel control words.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n) begin
                base_q[i] <= '{fc: '0, base: '0, wr_only: 1'b0, en: (i == 0)};
                opt_q[i]  <= OPT_RST;
            end else if (we && addr == RA_W'(2*i)) begin
                base_q[i] <= base_word_t'(wdata);
            end else if (we && addr == RA_W'(2*i+1)) begin
                opt_q[i]  <= opt_word_t'(wdata);
            end
        end
    end

    // Sticky violation flag: set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wpv_q <= 1'b0;
        else if (viol_evt)
            wpv_q <= 1'b1;
        else if (we && addr == STAT_IDX && wdata[0])
            wpv_q <= 1'b0;
    end

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == RA_W'(2*i))   rdata = base_q[i];
            if (addr == RA_W'(2*i+1)) rdata = opt_q[i];
        end
        if (addr == STAT_IDX) rdata = {{(CS_REG_W-1){1'b0}}, wpv_q};
    end
endmodule

// File: rtl/csel_match.sv
// One channel's comparator: address under mask, function code and direction.
// Purely combinational; the strobe is applied later by the arbiter.
module csel_match
    import csel_pkg::*;
(
    input  base_word_t            base_w,
    input  opt_word_t             opt_w,
    input  logic [CS_HI_W-1:0]    bus_hi,
    input  logic [CS_FC_W-1:0]    bus_fc,
    input  logic                  bus_read,
    output logic                  full_hit,
    output logic                  prot_hit
);
    logic addr_ok, fc_ok, dir_ok, region_hit;

    // Compare the region, then qualify with direction.
    always_comb begin
        addr_ok    = ((bus_hi ^ base_w.base) & opt_w.mask) == '0;
        fc_ok      = !opt_w.fc_chk || (bus_fc == base_w.fc);
        dir_ok     = !opt_w.dir_chk || (base_w.wr_only ? !bus_read : bus_read);
        region_hit = base_w.en && addr_ok && fc_ok;
        full_hit   = region_hit && dir_ok;
        prot_hit   = region_hit && opt_w.dir_chk && !base_w.wr_only && !bus_read;
    end
endmodule

// File: rtl/csel_arb.sv
// Picks the lowest-numbered matching channel, times the acknowledge and
// flags write-protect violations. Assumes the strobe returns high between cycles.
module csel_arb
    import csel_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      as_n,
    input  logic [NUM_CH-1:0]         full_hit,
    input  logic [NUM_CH-1:0]         prot_hit,
    input  opt_word_t [NUM_CH-1:0]    opt_q,
    output logic [NUM_CH-1:0]         cs_n,
    output logic                      dtack_n,
    output logic                      berr_n,
    output logic                      viol_evt
);
    logic [NUM_CH-1:0]   win;
    logic                found;
    logic [CS_WST_W-1:0] wst_sel;
    logic [CS_WST_W-1:0] cnt_q;
    logic                viol;

    // Fixed priority: lowest index wins.
    always_comb begin
        win     = '0;
        found   = 1'b0;
        wst_sel = WST_EXT;
        for (int i = 0; i < NUM_CH; i++) begin
            if (full_hit[i] && !found) begin
                win[i]  = 1'b1;
                found   = 1'b1;
                wst_sel = opt_q[i].wst;
            end
        end
    end

    // Count clock edges seen with the strobe low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || as_n)
            cnt_q <= '0;
        else if (cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
    end

    // Drive the bus-side outputs.
    always_comb begin
        viol     = !as_n && !found && |prot_hit;
        viol_evt = viol;
        berr_n   = !viol;
        cs_n     = as_n ? '1 : ~win;
        dtack_n  = !(!as_n && found && wst_sel != WST_EXT && cnt_q >= wst_sel);
    end
endmodule

// File: rtl/csel_unit.sv
// Top of the chip-select decoder: register file, per-channel comparators
// and arbiter. Address bits below the 8 KB granule are not decoded.
module csel_unit
    import csel_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 24,
    localparam int BLK_LSB = ADDR_W - CS_HI_W,
    localparam int RA_W    = $clog2(2*NUM_CH+1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [RA_W-1:0]        reg_addr,
    input  logic [CS_REG_W-1:0]    reg_wdata,
    output logic [CS_REG_W-1:0]    reg_rdata,
    input  logic                   bus_as_n,
    input  logic [ADDR_W-1:BLK_LSB] bus_addr,
    input  logic [CS_FC_W-1:0]     bus_fc,
    input  logic                   bus_read,
    output logic [NUM_CH-1:0]      cs_n,
    output logic                   dtack_n,
    output logic                   berr_n,
    output logic                   wpv
);
    base_word_t [NUM_CH-1:0] base_q;
    opt_word_t  [NUM_CH-1:0] opt_q;
    logic [NUM_CH-1:0]       full_hit, prot_hit;
    logic                    viol_evt;

    csel_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .viol_evt(viol_evt), .base_q(base_q),
        .opt_q(opt_q), .wpv_q(wpv), .rdata(reg_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        csel_match u_match (
            .base_w(base_q[c]), .opt_w(opt_q[c]), .bus_hi(bus_addr),
            .bus_fc(bus_fc), .bus_read(bus_read),
            .full_hit(full_hit[c]), .prot_hit(prot_hit[c])
        );
    end

    csel_arb #(.NUM_CH(NUM_CH)) u_arb (
        .clk(clk), .rst_n(rst_n), .as_n(bus_as_n), .full_hit(full_hit),
        .prot_hit(prot_hit), .opt_q(opt_q), .cs_n(cs_n),
        .dtack_n(dtack_n), .berr_n(berr_n), .viol_evt(viol_evt)
    );
endmodule

// File: rtl/csel_unit_chk.sv
// Port-level properties of the chip-select decoder, bound to every instance.
module csel_unit_chk #(
    parameter int NUM_CH = 4,
    localparam int RA_W  = $clog2(2*NUM_CH+1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [RA_W-1:0]   reg_addr,
    input logic [15:0]       reg_wdata,
    input logic              bus_as_n,
    input logic [NUM_CH-1:0] cs_n,
    input logic              dtack_n,
    input logic              berr_n,
    input logic              wpv
);
    localparam logic [RA_W-1:0] STAT_IDX = RA_W'(2*NUM_CH);
    logic clr_wr;
    assign clr_wr = reg_we && reg_addr == STAT_IDX && reg_wdata[0];

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) bus_as_n |-> (&cs_n && dtack_n && berr_n)); // R7
    AST_BERR_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n) !berr_n |-> (&cs_n && dtack_n)); // R8
    AST_VIOL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) !berr_n |=> wpv); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (wpv && !clr_wr) |=> wpv); // R9
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr_wr && berr_n) |=> !wpv); // R9
    AST_ACK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n) !dtack_n |-> !(&cs_n)); // R10
endmodule

bind csel_unit csel_unit_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/csel_unit_test.sv
module csel_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_as_n = 1'b1;
    logic [23:13] bus_addr = '0;
    logic [2:0]  bus_fc = '0;
    logic        bus_read = 1'b1;
    logic [3:0]  cs_n;
    logic        dtack_n, berr_n, wpv;

    int checks = 0;
    int errors = 0;
    logic [15:0] mb [4];
    logic [15:0] mo [4];

    csel_unit uut (.*);

    always #2 clk = ~clk;   // 250 MHz

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1 chk(tag, reg_rdata, exp);
    endtask

    // Expected {violation, select vector} from the programmed words.
    function automatic logic [4:0] model(input logic [10:0] hi, input logic [2:0] fc, input logic rd);
        logic [3:0] sel = '0;
        logic found = 1'b0, prot = 1'b0;
        for (int i = 0; i < 4; i++) begin
            logic reg_hit, dir_ok;
            reg_hit = mb[i][0] && (((hi ^ mb[i][12:2]) & mo[i][12:2]) == 11'd0)
                      && (!mo[i][0] || fc == mb[i][15:13]);
            dir_ok  = !mo[i][1] || (mb[i][1] ? !rd : rd);
            if (reg_hit && dir_ok && !found) begin sel[i] = 1'b1; found = 1'b1; end
            if (reg_hit && mo[i][1] && !mb[i][1] && !rd) prot = 1'b1;
        end
        return {!found && prot, sel};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset contents and boot selection
        for (int i = 0; i < 4; i++) begin
            rd_chk("R2 base reset", 4'(2*i), (i == 0) ? 16'h0001 : 16'h0000);
            rd_chk("R2 option reset", 4'(2*i+1), 16'hC000);
        end
        rd_chk("R2 flag reset", 4'd8, 16'h0000);
        chk("R2 wpv reset", {15'd0, wpv}, 16'd0);
        chk("R7 idle lines", {12'd0, cs_n}, 16'h000F);
        bus_as_n = 1'b0; bus_addr = 11'h5A3; bus_fc = 3'd6; bus_read = 1'b1;
        #1 chk("R2 boot read select", {12'd0, cs_n}, 16'h000E);
        bus_read = 1'b0;
        #1 chk("R2 boot write select", {12'd0, cs_n}, 16'h000E);
        chk("R2 boot no error", {15'd0, berr_n}, 16'd1);
        @(negedge clk); bus_as_n = 1'b1; bus_read = 1'b1;

        // R10: acknowledge timing for every wait code
        for (int w = 0; w < 8; w++) begin
            wr(4'd1, {3'(w), 13'd0});
            @(negedge clk);
            bus_as_n = 1'b0;
            for (int n = 0; n < 10; n++) begin
                #1 chk($sformatf("R10 wait=%0d edge=%0d", w, n), {15'd0, dtack_n},
                       {15'd0, !(w != 7 && n >= w)});
                @(negedge clk);
            end
            bus_as_n = 1'b1;
        end

        // R1: program the sweep layout and read it back
        mb[0] = 16'h0000;                        mo[0] = 16'h0000;
        mb[1] = {3'd5, 11'h100, 1'b1, 1'b1};     mo[1] = {3'd2, 11'h7F8, 1'b1, 1'b1};
        mb[2] = {3'd0, 11'h100, 1'b0, 1'b1};     mo[2] = {3'd1, 11'h780, 1'b1, 1'b0};
        mb[3] = {3'd7, 11'h000, 1'b0, 1'b1};     mo[3] = {3'd0, 11'h000, 1'b0, 1'b1};
        for (int i = 0; i < 4; i++) begin
            wr(4'(2*i), mb[i]);
            wr(4'(2*i+1), mo[i]);
        end
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            rd_chk("R1 base readback", 4'(2*i), mb[i]);
            rd_chk("R1 option readback", 4'(2*i+1), mo[i]);
        end
        chk("R9 flag clear before sweep", {15'd0, wpv}, 16'd0);

        // R3 R4 R5 R6 R7 R8: sweep every granule, code and direction
        bus_as_n = 1'b0;
        for (int hi = 0; hi < 2048; hi++) begin
            for (int fc = 0; fc < 8; fc++) begin
                for (int r = 0; r < 2; r++) begin
                    logic [4:0] e;
                    @(negedge clk);
                    bus_addr = 11'(hi); bus_fc = 3'(fc); bus_read = 1'(r);
                    e = model(11'(hi), 3'(fc), 1'(r));
                    #1;
                    chk($sformatf("R3 R4 R5 R6 R7 sel a=%h fc=%0d rd=%0d", hi, fc, r),
                        {12'd0, cs_n}, {12'd0, ~e[3:0]});
                    chk($sformatf("R8 berr a=%h fc=%0d rd=%0d", hi, fc, r),
                        {15'd0, berr_n}, {15'd0, !e[4]});
                end
            end
        end

        // R8 R9: one isolated violation, then normal cycles keep the flag
        @(negedge clk); bus_as_n = 1'b1;
        wr(4'd8, 16'h0001);
        @(negedge clk);
        chk("R9 cleared by write one", {15'd0, wpv}, 16'd0);
        bus_as_n = 1'b0; bus_addr = 11'h140; bus_fc = 3'd1; bus_read = 1'b0;
        #1 chk("R8 violation berr", {15'd0, berr_n}, 16'd0);
        chk("R8 violation no select", {12'd0, cs_n}, 16'h000F);
        @(negedge clk); bus_as_n = 1'b1;
        chk("R8 flag set after violation", {15'd0, wpv}, 16'd1);
        bus_as_n = 1'b0; bus_addr = 11'h100; bus_fc = 3'd5; bus_read = 1'b0;
        @(negedge clk); bus_as_n = 1'b1;
        @(negedge clk);
        chk("R9 flag sticky", {15'd0, wpv}, 16'd1);
        rd_chk("R1 status shows flag", 4'd8, 16'h0001);
        wr(4'd8, 16'h0000);
        @(negedge clk);
        chk("R9 write zero keeps flag", {15'd0, wpv}, 16'd1);
        // R9: violation and clear in the same cycle, violation wins
        bus_as_n = 1'b0; bus_addr = 11'h140; bus_fc = 3'd1; bus_read = 1'b0;
        reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 16'h0001;
        @(negedge clk);
        reg_we = 1'b0; bus_as_n = 1'b1;
        chk("R9 set wins over clear", {15'd0, wpv}, 16'd1);
        wr(4'd8, 16'h0001);
        @(negedge clk);
        chk("R9 final clear", {15'd0, wpv}, 16'd0);

        // R4: all channels disabled, nothing selects or errors
        for (int i = 0; i < 4; i++) wr(4'(2*i), {mb[i][15:1], 1'b0});
        @(negedge clk);
        bus_as_n = 1'b0; bus_addr = 11'h140; bus_fc = 3'd7; bus_read = 1'b0;
        #1 chk("R4 disabled no select", {12'd0, cs_n}, 16'h000F);
        chk("R4 disabled no error", {15'd0, berr_n}, 16'd1);
        @(negedge clk); bus_as_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule